// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

This block takes two 32-bit single-precision operands and decides how they relate: less, equal, greater or unordered. It reports the relation as four condition flags (negative, zero, carry, overflow) that can be merged into a processor status word. It also reports an invalid-operation event when either operand is a signalling NaN. The result appears one clock after an input strobe, together with an output strobe.

Internally each operand is sorted into one of six classes: zero, denormal, normal, infinity, quiet NaN and signalling NaN. A NaN of either kind forces an unordered result. A signalling NaN also raises the event. Ordered operands are compared as sign-magnitude words, and a zero of either sign takes part as an unsigned zero. A flush control input makes denormal operands behave as zeros. This breaks strict standard conformance and shortens nothing, but software that runs with flushed denormals expects it.

Top module: `fcmp_unit`

## Requirements
- R1: While reset is asserted and after it is released, out_valid, invalid_evt and all four flags are 0 until the first accepted input.
- R2: out_valid is 1 exactly in the cycle after a cycle with in_valid at 1. The flags keep their last value through cycles with no accepted input.
- R3: The flags {flag_n, flag_z, flag_c, flag_v} are 4'b1000 for less (op_a < op_b), 4'b0110 for equal, 4'b0010 for greater and 4'b0011 for unordered.
- R4: A word with exponent bits [30:23] all ones and a nonzero fraction [22:0] is a NaN. Any NaN operand gives unordered, including a NaN compared with itself.
- R5: Positive zero (0x00000000) and negative zero (0x80000000) compare equal, to each other and to themselves.
- R6: invalid_evt is 1 with out_valid when either operand is a signalling NaN, which is a NaN with fraction bit 22 at 0. A quiet NaN (bit 22 at 1) alone leaves invalid_evt at 0.
- R7: An infinity (exponent all ones, zero fraction) carries its sign in bit 31. +inf is greater than every finite value, -inf is less than every finite value, and each infinity equals itself.
- R8: Ordered finite non-zero values compare by sign and magnitude. With equal signs, bits [30:0] are compared, and the result is reversed for negatives. With different signs, the negative value is less.
- R9: With flush_den at 1, a denormal (exponent 0, nonzero fraction) of either sign compares equal to zero and to any other denormal. With flush_den at 0, a denormal is ordered by its magnitude bits.
- R10: invalid_evt is 0 in every cycle in which out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are presented this cycle |
| op_a | input | 32 | First single-precision operand |
| op_b | input | 32 | Second single-precision operand |
| flush_den | input | 1 | Treat denormal operands as zero |
| out_valid | output | 1 | Result is presented this cycle |
| flag_n | output | 1 | Negative flag, set for less |
| flag_z | output | 1 | Zero flag, set for equal |
| flag_c | output | 1 | Carry flag, set for equal, greater or unordered |
| flag_v | output | 1 | Overflow flag, set for unordered |
| invalid_evt | output | 1 | Invalid-operation event for a signalling NaN input |

## Verification
The unordered relation and the invalid-operation event are produced by separate paths, and both are captured in the same output cycle when an operand is a signalling NaN. The sweep pairs every representative value, including both signalling and quiet NaNs of both signs, with every other value under both flush settings. Each result is judged on the complete flag nibble and the event bit together, against a relation the bench derives from a signed ordering key. The flush control and the zero rule also meet in one cycle when a denormal is paired with a zero of the opposite sign, and those pairs are judged as equal or as ordered according to flush_den.

// File: rtl/fcmp_unit.sv
module fcmp_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [EXP_W+FRAC_W:0]       op_a,
  input  logic [EXP_W+FRAC_W:0]       op_b,
  input  logic                        flush_den,
  output logic                        out_valid,
  output logic                        flag_n,
  output logic                        flag_z,
  output logic                        flag_c,
  output logic                        flag_v,
  output logic                        invalid_evt
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int MAG_W = W - 1;
  localparam int C_ZERO = 0, C_DEN = 1, C_NORM = 2, C_INF = 3, C_QNAN = 4, C_SNAN = 5;

  function automatic logic [5:0] classify(input logic [W-1:0] x);
    logic e_ones, e_zero, f_nz;
    e_ones = &x[W-2:FRAC_W];
    e_zero = ~|x[W-2:FRAC_W];
    f_nz   = |x[FRAC_W-1:0];
    classify         = '0;
    classify[C_ZERO] = e_zero & ~f_nz;
    classify[C_DEN]  = e_zero &  f_nz;
    classify[C_NORM] = ~e_zero & ~e_ones;
    classify[C_INF]  = e_ones & ~f_nz;
    classify[C_QNAN] = e_ones &  f_nz &  x[FRAC_W-1];
    classify[C_SNAN] = e_ones &  f_nz & ~x[FRAC_W-1];
  endfunction

  logic [5:0]       cls_a, cls_b;
  logic             zero_a, zero_b, sgn_a, sgn_b;
  logic [MAG_W-1:0] mag_a, mag_b;
  logic             unord, is_eq, is_lt, snan_any;
  logic [3:0]       nzcv_d, nzcv_q;

  assign cls_a = classify(op_a);
  assign cls_b = classify(op_b);

  assign zero_a = cls_a[C_ZERO] | (flush_den & cls_a[C_DEN]);
  assign zero_b = cls_b[C_ZERO] | (flush_den & cls_b[C_DEN]);

  assign mag_a = zero_a ? '0 : op_a[MAG_W-1:0];
  assign mag_b = zero_b ? '0 : op_b[MAG_W-1:0];
  assign sgn_a = ~zero_a & op_a[W-1];
  assign sgn_b = ~zero_b & op_b[W-1];

  assign unord    = cls_a[C_QNAN] | cls_a[C_SNAN] | cls_b[C_QNAN] | cls_b[C_SNAN];
  assign snan_any = cls_a[C_SNAN] | cls_b[C_SNAN];
  assign is_eq    = (sgn_a == sgn_b) && (mag_a == mag_b);
  assign is_lt    = (sgn_a != sgn_b) ? sgn_a
                  : (sgn_a ? (mag_b < mag_a) : (mag_a < mag_b));

  always_comb begin
    if (unord)      nzcv_d = 4'b0011;
    else if (is_eq) nzcv_d = 4'b0110;
    else if (is_lt) nzcv_d = 4'b1000;
    else            nzcv_d = 4'b0010;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      invalid_evt <= 1'b0;
      nzcv_q      <= 4'b0000;
    end else begin
      out_valid   <= in_valid;
      invalid_evt <= in_valid & snan_any;
      if (in_valid) nzcv_q <= nzcv_d;
    end
  end

  assign {flag_n, flag_z, flag_c, flag_v} = nzcv_q;
endmodule

module fcmp_unit_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  out_valid,
  input logic                  flag_n,
  input logic                  flag_z,
  input logic                  flag_c,
  input logic                  flag_v,
  input logic                  invalid_evt
);
  localparam int W = 1 + EXP_W + FRAC_W;
  logic nan_a, nan_b, sn_a, sn_b, zz;
  logic [3:0] fl;
  assign nan_a = (&op_a[W-2:FRAC_W]) & (|op_a[FRAC_W-1:0]);
  assign nan_b = (&op_b[W-2:FRAC_W]) & (|op_b[FRAC_W-1:0]);
  assign sn_a  = nan_a & ~op_a[FRAC_W-1];
  assign sn_b  = nan_b & ~op_b[FRAC_W-1];
  assign zz    = (op_a[W-2:0] == '0) && (op_b[W-2:0] == '0);
  assign fl    = {flag_n, flag_z, flag_c, flag_v};

  AST_VALID_NEXT:  assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);   // R2
  AST_VALID_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
  AST_FLAGS_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(fl)); // R2
  AST_FLAG_CODE:   assert property (@(posedge clk) disable iff (!rst_n)
                     out_valid |-> (fl == 4'b1000 || fl == 4'b0110 || fl == 4'b0010 || fl == 4'b0011)); // R3
  AST_NAN_UNORD:   assert property (@(posedge clk) disable iff (!rst_n)
                     in_valid && (nan_a || nan_b) |=> (fl == 4'b0011)); // R4
  AST_ZERO_EQ:     assert property (@(posedge clk) disable iff (!rst_n)
                     in_valid && zz |=> (fl == 4'b0110)); // R5
  AST_SNAN_EVT:    assert property (@(posedge clk) disable iff (!rst_n)
                     in_valid && (sn_a || sn_b) |=> invalid_evt); // R6
  AST_QNAN_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
                     in_valid && !sn_a && !sn_b |=> !invalid_evt); // R6
  AST_EVT_STROBE:  assert property (@(posedge clk) disable iff (!rst_n) invalid_evt |-> out_valid); // R10
endmodule

bind fcmp_unit fcmp_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .out_valid(out_valid), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
  .flag_v(flag_v), .invalid_evt(invalid_evt)
);

// File: tb/fcmp_unit_tb_top.sv
module fcmp_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, flush_den = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic out_valid, flag_n, flag_z, flag_c, flag_v, invalid_evt;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .flush_den(flush_den), .out_valid(out_valid), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .invalid_evt(invalid_evt)
  );

  function automatic logic [31:0] pick(input int i);
    logic [30:0] m;
    case (i % 10)
      0: m = 31'h00000000;
      1: m = 31'h00000001;
      2: m = 31'h007FFFFF;
      3: m = 31'h00800000;
      4: m = 31'h3F800000;
      5: m = 31'h3FC00000;
      6: m = 31'h7F7FFFFF;
      7: m = 31'h7F800000;
      8: m = 31'h7FC00000;
      default: m = 31'h7F800001;
    endcase
    if (i >= 10 && (i % 10) >= 8) m = m | 31'h10;
    return {i >= 10, m};
  endfunction

  function automatic bit is_nan(input logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction

  function automatic bit is_den(input logic [31:0] x);
    return x[30:23] == 0 && x[22:0] != 0;
  endfunction

  function automatic longint key(input logic [31:0] x, input bit fz);
    longint m;
    m = (x[30:23] == 0 && (fz || x[22:0] == 0)) ? 0 : longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp, input string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    logic [3:0]  held;
    repeat (3) @(negedge clk);
    check("R1", {out_valid, flag_n, flag_z, flag_c, flag_v}, 5'b0, "in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, flag_n, flag_z, flag_c, flag_v}, 5'b0, "after reset");
    check("R10", {4'b0, invalid_evt}, 5'b0, "event after reset");

    for (int fz = 0; fz < 2; fz++) begin
      for (int i = 0; i < 20; i++) begin
        for (int j = 0; j < 20; j++) begin
          logic [3:0] e_fl;
          bit e_inv;
          string tag;
          a = pick(i);
          b = pick(j);
          op_a = a; op_b = b; flush_den = fz[0]; in_valid = 1'b1;
          @(negedge clk);
          // R3 encoding of the relation
          if (is_nan(a) || is_nan(b))        e_fl = 4'b0011;
          else if (key(a, fz[0]) == key(b, fz[0])) e_fl = 4'b0110;
          else if (key(a, fz[0]) <  key(b, fz[0])) e_fl = 4'b1000;
          else                               e_fl = 4'b0010;
          e_inv = (is_nan(a) && !a[22]) || (is_nan(b) && !b[22]);
          if (is_nan(a) || is_nan(b))                      tag = e_inv ? "R6" : "R4";
          else if (a[30:23] == 8'hFF || b[30:23] == 8'hFF) tag = "R7";
          else if (is_den(a) || is_den(b))                 tag = "R9";
          else if (a[30:0] == 0 && b[30:0] == 0)           tag = "R5";
          else                                             tag = "R8";
          check(tag, {out_valid, flag_n, flag_z, flag_c, flag_v}, {1'b1, e_fl},
                $sformatf("R3 flags a=%h b=%h fz=%0d", a, b, fz));
          check(tag, {4'b0, invalid_evt}, {4'b0, e_inv},
                $sformatf("event a=%h b=%h fz=%0d", a, b, fz));
        end
      end
    end

    op_a = 32'h7F800001; op_b = 32'h3F800000; in_valid = 1'b1;
    @(negedge clk);
    check("R6", {4'b0, invalid_evt}, 5'b1, "signalling NaN event");
    held = {flag_n, flag_z, flag_c, flag_v};
    in_valid = 1'b0; op_a = 32'h00000000; op_b = 32'h3F800000;
    @(negedge clk);
    check("R2", {out_valid, flag_n, flag_z, flag_c, flag_v}, {1'b0, held}, "idle hold");
    check("R10", {4'b0, invalid_evt}, 5'b0, "event idle");
    @(negedge clk);
    check("R2", {out_valid, flag_n, flag_z, flag_c, flag_v}, {1'b0, held}, "second idle hold");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule